// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between the byte-level engine of a two-wire serial memory slave and the memory array. The engine hands it a word address and then a stream of data bytes. The block keeps those bytes in a small page register that holds one entry per byte position in the page, with a valid flag for each entry. No byte reaches the array until the engine reports the end of the transaction. The block then walks the page, writes each valid entry through a single memory write port, and holds a busy flag while a self-timed cycle runs.

The upper address bits stay fixed for the whole transaction. Only the in-page index advances, and it wraps inside the page, so extra bytes overwrite earlier ones. A repeated start discards the page. When the write-protect input is high, every data byte is refused, and the end of the transaction starts nothing. The length of the timed cycle is a parameter counted in clocks.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o` and `ack_vld_o` are low.
- R2: A byte accepted while the index is i and the upper address is u is written to array address {u, i} when the transaction ends with a stop. The upper part is bits [7:4] of the loaded address and i starts at bits [3:0].
- R3: Each accepted byte advances only the 4-bit index, modulo 16. A 17th or later byte overwrites the entry at its index, and the upper bits never change.
- R4: During a commit, the array receives exactly one write per valid entry and no write for an empty entry.
- R5: No array write and no busy happen before `stop_i`. Buffered bytes stay invisible at the memory port until then.
- R6: `restart_i` empties the page, so a following stop writes nothing and raises no busy.
- R7: While `wp_i` is high, a data byte is answered with `ack_vld_o`=1 and `ack_o`=0. The rest of that transaction is refused the same way, and its stop starts no cycle.
- R8: After a stop with at least one valid entry, `busy_o` stays high for exactly PAGE_BYTES + CYCLE_CLKS clock cycles.
- R9: While busy, address and byte strobes are ignored. A byte is answered with `ack_o`=0 and is not stored, and a loaded address does not replace the current address.
- R10: Every `byte_load_i` is answered one cycle later with `ack_vld_o`=1. `ack_o`=1 means the byte was stored.
- R11: The valid flags clear when the cycle completes, so a second stop with no new bytes starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect; high refuses data bytes |
| addr_load_i | input | 1 | Strobe: load word address |
| addr_i | input | ADDR_W | Word address to load |
| byte_load_i | input | 1 | Strobe: one data byte received |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Strobe: transaction ended by stop |
| restart_i | input | 1 | Strobe: repeated start seen |
| ack_vld_o | output | 1 | Response to a byte strobe is valid |
| ack_o | output | 1 | 1 = byte stored, 0 = refused |
| busy_o | output | 1 | Commit and timed cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The hardest situation to reach is strobes that arrive in the middle of a commit. They must change neither the page nor the address pointer, and the only way to see this from the ports is the address used by the next transaction. The stimulus sends an address and a byte during the busy window. It then sends a byte with no new address once busy has dropped, and checks that this byte lands where the earlier transaction left the index. Wrapping and write protect switching on in the middle of a page are reached by random transactions of up to 20 bytes, with random protect and random restart or stop endings.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_WAIT   = 2'd2
  } pws_state_t;
endpackage

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  clr_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [PAGE_BYTES-1:0] valid_o
);
  // data storage carries no reset so it can map onto RAM
  logic [DATA_W-1:0] data_q [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en_i) data_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = data_q[rd_idx_i];

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_vld
      always_ff @(posedge clk) begin
        if (rst || clr_i)                                   valid_o[g] <= 1'b0;
        else if (wr_en_i && wr_idx_i == IDX_W'(g))          valid_o[g] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer #(
  parameter int CYCLE_CLKS = 500000,
  localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(CYCLE_CLKS - 1);
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,      // power of two, so the index wraps
  parameter int CYCLE_CLKS = 500000   // self-timed cycle length in clocks
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_load_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              restart_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  import pws_pkg::*;

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  pws_state_t              state_q;
  logic [BASE_W-1:0]       base_q;
  logic [IDX_W-1:0]        idx_q;
  logic [IDX_W-1:0]        scan_q;
  logic                    blk_q;
  logic [PAGE_BYTES-1:0]   valid;
  logic [DATA_W-1:0]       rd_data;
  logic                    tmr_done;

  logic idle, accept, go_commit, tmr_start, clr_buf;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && byte_load_i && !stop_i && !restart_i && !wp_i && !blk_q;
  assign go_commit = idle && stop_i && (|valid) && !blk_q;
  assign tmr_start = (state_q == ST_COMMIT) && (scan_q == LAST_IDX);
  assign clr_buf   = (idle && restart_i && !stop_i) ||
                     (idle && stop_i && !go_commit) || tmr_done;
  assign busy_o    = !idle;

  pws_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (accept),
    .wr_idx_i  (idx_q),
    .wr_data_i (byte_i),
    .clr_i     (clr_buf),
    .rd_idx_i  (scan_q),
    .rd_data_o (rd_data),
    .valid_o   (valid)
  );

  pws_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      idx_q       <= '0;
      scan_q      <= '0;
      blk_q       <= 1'b0;
      ack_vld_o   <= 1'b0;
      ack_o       <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      ack_vld_o <= byte_load_i;
      ack_o     <= accept;
      mem_we_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (stop_i) begin
            blk_q <= 1'b0;
            if (go_commit) begin
              state_q <= ST_COMMIT;
              scan_q  <= '0;
            end
          end else if (restart_i) begin
            blk_q <= 1'b0;
          end else if (byte_load_i) begin
            if (accept) idx_q <= idx_q + 1'b1;
            else        blk_q <= 1'b1;
          end else if (addr_load_i) begin
            base_q <= addr_i[ADDR_W-1:IDX_W];
            idx_q  <= addr_i[IDX_W-1:0];
          end
        end
        ST_COMMIT: begin
          mem_we_o    <= valid[scan_q];
          mem_addr_o  <= {base_q, scan_q};
          mem_wdata_o <= rd_data;
          scan_q      <= scan_q + 1'b1;
          if (scan_q == LAST_IDX) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tmr_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int PAGE_BYTES = 16,
  parameter int CYCLE_CLKS = 500000
) (
  input logic clk,
  input logic rst,
  input logic wp_i,
  input logic byte_load_i,
  input logic stop_i,
  input logic restart_i,
  input logic ack_vld_o,
  input logic ack_o,
  input logic busy_o,
  input logic mem_we_o
);
  localparam int TOTAL = PAGE_BYTES + CYCLE_CLKS;
  localparam int CW    = $clog2(TOTAL + 2);

  logic [CW-1:0] busy_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_cnt_q <= '0;
    else                busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  // R1: idle outputs in the first cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !busy_o && !mem_we_o && !ack_vld_o);
  // R5: array writes only inside a busy window
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (rst) mem_we_o |-> busy_o);
  // R5: busy only begins after a stop strobe
  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> $past(stop_i));
  // R7: protected byte is refused
  a_r7_wp_nack: assert property (@(posedge clk) disable iff (rst) byte_load_i && wp_i |=> ack_vld_o && !ack_o);
  // R9: byte during busy is refused
  a_r9_busy_nack: assert property (@(posedge clk) disable iff (rst) byte_load_i && busy_o |=> !ack_o);
  // R10: every byte strobe is answered next cycle
  a_r10_ack_resp: assert property (@(posedge clk) disable iff (rst) byte_load_i |=> ack_vld_o);
  // R6: a restart never starts a cycle
  a_r6_restart_quiet: assert property (@(posedge clk) disable iff (rst) restart_i && !stop_i && !busy_o |=> !busy_o);
  // R8: busy window length
  a_r8_busy_len: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> busy_cnt_q == CW'(TOTAL));
endmodule

bind page_write_seq pws_checker #(.PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wp_i        (wp_i),
  .byte_load_i (byte_load_i),
  .stop_i      (stop_i),
  .restart_i   (restart_i),
  .ack_vld_o   (ack_vld_o),
  .ack_o       (ack_o),
  .busy_o      (busy_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/page_write_seq_tb_top.sv
module page_write_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, PB = 16, CYC = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic wp = 1'b0, addr_load = 1'b0, byte_load = 1'b0, stop = 1'b0, restart = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] bdata = '0;
  logic ack_vld_o, ack_o, busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst(rst), .wp_i(wp), .addr_load_i(addr_load), .addr_i(addr),
    .byte_load_i(byte_load), .byte_i(bdata), .stop_i(stop), .restart_i(restart),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [DW-1:0] mem_act [256];
  logic [DW-1:0] mem_exp [256];
  logic [DW-1:0] pb_d [PB];
  bit            pb_v [PB];
  int m_base = 0, m_idx = 0;
  bit m_blk = 0;

  always @(negedge clk) begin
    if (!rst && mem_we_o) begin
      mem_act[mem_addr_o] = mem_wdata_o;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int valid_count();
    int n = 0;
    for (int i = 0; i < PB; i++) if (pb_v[i]) n++;
    return n;
  endfunction

  task automatic load_addr(input int a);
    bit b;
    @(negedge clk); b = busy_o; addr_load = 1'b1; addr = AW'(a);
    @(negedge clk); addr_load = 1'b0;
    if (!b) begin m_base = a / PB; m_idx = a % PB; end
  endtask

  task automatic send_byte(input int d, input string req);
    bit b, exp_ack;
    @(negedge clk); b = busy_o; byte_load = 1'b1; bdata = DW'(d);
    exp_ack = !b && !wp && !m_blk;
    @(negedge clk); byte_load = 1'b0;
    chk(ack_vld_o == 1'b1, "R10 ack_vld", ack_vld_o, 1);
    chk(ack_o == exp_ack, req, ack_o, exp_ack);
    if (!b) begin
      if (exp_ack) begin pb_d[m_idx] = DW'(d); pb_v[m_idx] = 1; m_idx = (m_idx + 1) % PB; end
      else m_blk = 1;
    end
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk(busy_o == 1'b0, "R6 restart no busy", busy_o, 0);
    for (int i = 0; i < PB; i++) pb_v[i] = 0;
    m_blk = 0;
  endtask

  // stop, optionally poke strobes during busy, wait for idle, compare memory
  task automatic do_stop(input bit meddle, input string req);
    bit go;
    int n, w0, nv, bad;
    go = (valid_count() > 0) && !m_blk;
    nv = go ? valid_count() : 0;
    w0 = wr_cnt;
    if (go) for (int i = 0; i < PB; i++) if (pb_v[i]) mem_exp[m_base*PB + i] = pb_d[i];
    for (int i = 0; i < PB; i++) pb_v[i] = 0;
    m_blk = 0;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    n = 0;
    if (meddle) begin
      chk(busy_o == 1'b1, "R9 busy during poke", busy_o, 1);
      load_addr(8'hF0);
      send_byte(8'h77, "R9 byte refused while busy");
      n = -1;
    end
    while (busy_o) begin n = (n < 0) ? n : n + 1; @(negedge clk); end
    if (!meddle) chk(n == (go ? PB + CYC : 0), "R8 busy length", n, go ? PB + CYC : 0);
    chk((wr_cnt - w0) == nv, "R4 write count", wr_cnt - w0, nv);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem_act[i] !== mem_exp[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int a, nb;
    void'($urandom(32'd12345));
    for (int i = 0; i < 256; i++) begin mem_act[i] = '0; mem_exp[i] = '0; end
    for (int i = 0; i < PB; i++) pb_v[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && mem_we_o == 0 && ack_vld_o == 0, "R1 reset state",
        {busy_o, mem_we_o, ack_vld_o}, 0);

    // R2 single byte
    load_addr(8'h35); send_byte(8'hA5, "R2 byte accepted"); do_stop(0, "R2 byte write memory");

    // R3 wrap: 20 bytes from index 12
    load_addr(8'h4C);
    for (int i = 0; i < 20; i++) send_byte(8'h10 + i, "R3 wrap byte ack");
    do_stop(0, "R3 wrap memory");

    // R4/R5 partial page, nothing before stop
    load_addr(8'h63);
    for (int i = 0; i < 3; i++) send_byte(8'hC0 + i, "R4 partial ack");
    a = wr_cnt;
    chk(wr_cnt == a && busy_o == 0, "R5 no write before stop", busy_o, 0);
    repeat (5) @(negedge clk);
    chk(wr_cnt == a, "R5 still no write", wr_cnt - a, 0);
    do_stop(0, "R4 partial memory");

    // R6 restart discards
    load_addr(8'h80); send_byte(8'h11, "R6 ack"); send_byte(8'h22, "R6 ack");
    do_restart(); do_stop(0, "R6 no commit after restart");

    // R7 write protect
    wp = 1'b1; load_addr(8'h90);
    send_byte(8'h33, "R7 protected byte nack"); send_byte(8'h44, "R7 protected byte nack");
    do_stop(0, "R7 no commit under protect");
    wp = 1'b0;

    // R9 strobes while busy, then continue with old pointer
    load_addr(8'h10); send_byte(8'h01, "R9 ack"); send_byte(8'h02, "R9 ack");
    do_stop(1, "R9 memory after poke");
    send_byte(8'h5A, "R9 byte after busy");
    do_stop(0, "R9 pointer kept (expect 0x12)");
    chk(mem_act[8'h12] == 8'h5A, "R9 address 0x12", mem_act[8'h12], 8'h5A);
    chk(mem_act[8'hF0] == 8'h00, "R9 address 0xF0 untouched", mem_act[8'hF0], 0);

    // R11 flags cleared after cycle
    do_stop(0, "R11 second stop no commit");

    // random transactions
    for (int t = 0; t < 30; t++) begin
      load_addr($urandom_range(255));
      nb = $urandom_range(20, 1);
      for (int k = 0; k < nb; k++) begin
        wp = ($urandom_range(9) == 0);
        send_byte($urandom_range(255), "R3 random ack");
      end
      wp = 1'b0;
      if ($urandom_range(4) == 0) do_restart();
      do_stop(0, "R2 random memory");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule